// File: doc/BRIEF.md
# Bus-Start Watchdog Timer

This block supervises a host processor by watching the two wires of a serial bus. Each START condition on the bus counts as the host's keep-alive. A START is SDA falling while SCL is high. Both bus lines are resynchronised into the system clock domain. Time is measured in pulses of a slow timebase tick. If the selected number of ticks passes with no START, the block sends a one-cycle timeout request to the reset logic that sits beside it.

A two-bit period field selects one of three timeout lengths, or turns the watchdog off. A lock-enable bit sits in the same small configuration register. Software updates both through a write port. When the lock pin is high and the lock-enable bit is set, that port is blocked. The reset logic reports back through a hold input. While the hold input is high the count is frozen at zero. After each timeout the watchdog stays idle until a hold period has come and gone.

Top module: `bus_start_wdog`

## Requirements
- R1: A START restarts the tick count from zero. A START is SDA going from 1 to 0 while SCL is 1, taken after the two-flop synchronisers.
- R2: A falling SDA edge while SCL is 0 does not restart the count. A rising SDA edge while SCL is 1 does not restart the count either.
- R3: A one-cycle pulse appears on `timeout_o` once the selected number of ticks has been counted since the last restart with no START in between. This holds when SDA stays constantly high and when it stays constantly low.
- R4: Period code 2'b00 selects `TICKS_LONG`, 2'b01 selects `TICKS_MID` and 2'b10 selects `TICKS_SHORT`. Code 2'b11 disables the watchdog, so it never times out.
- R5: A write on `cfg_we_i` loads `cfg_period_i` and `cfg_wpen_i` at the next clock edge. The write is dropped, with both fields unchanged, when `wp_i` is 1 and the stored lock-enable bit is 1. The stored fields are readable on `period_o` and `wpen_o`.
- R6: While `rst_hold_i` is 1, the count is held at zero and no timeout is produced. Counting starts from zero once the input returns to 0.
- R7: After a timeout, no further timeout occurs until `rst_hold_i` has been high and then returned low.
- R8: After `rst_ni`, `period_o` is 2'b00, `wpen_o` is 0, `timeout_o` is 0, and the watchdog is armed with a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse, one cycle wide |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| wp_i | input | 1 | Lock pin for the configuration register |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_period_i | input | 2 | Period code to write |
| cfg_wpen_i | input | 1 | Lock-enable bit to write |
| rst_hold_i | input | 1 | High while the reset output is held active |
| period_o | output | 2 | Stored period code |
| wpen_o | output | 1 | Stored lock-enable bit |
| timeout_o | output | 1 | One-cycle timeout request |

## Verification
Every period code is exercised while SDA sits idle high. Each code is checked one tick short of its limit and again at the limit, which separates the three lengths from each other and from the disabled code. A proper START in the middle of a count is compared against SDA falling while SCL is low, and against a rising SDA edge while SCL is high. Only the real START moves the expiry point, so the trigger is shown to depend on the SCL level and the edge direction. SDA held low and ticks arriving during hold show that a stuck line still expires and that a held reset freezes the count. Writes are made under each combination of lock pin and lock-enable bit, which shows that the lock needs both of them.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  typedef enum logic [1:0] {
    PER_LONG  = 2'b00,
    PER_MID   = 2'b01,
    PER_SHORT = 2'b10,
    PER_OFF   = 2'b11
  } period_e;
endpackage

// File: rtl/bsw_sync.sv
module bsw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] rst_val_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0] chain [W];

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[b] <= {STAGES{rst_val_i[b]}};
      else         chain[b] <= {chain[b][STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/bsw_start_det.sv
module bsw_start_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o
);
  logic sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_prev <= 1'b1;
    else         sda_prev <= sda_i;
  end

  assign start_o = scl_i & sda_prev & ~sda_i;
endmodule

// File: rtl/bsw_cfg_reg.sv
module bsw_cfg_reg
  import bsw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       wp_i,
  input  logic [1:0] period_i,
  input  logic       wpen_i,
  output period_e    period_o,
  output logic       wpen_o
);
  logic locked;
  assign locked = wp_i & wpen_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= PER_LONG;
      wpen_o   <= 1'b0;
    end else if (we_i && !locked) begin
      period_o <= period_e'(period_i);
      wpen_o   <= wpen_i;
    end
  end
endmodule

// File: rtl/bsw_counter.sv
module bsw_counter
  import bsw_pkg::*;
#(
  parameter int TICKS_LONG  = 1400,
  parameter int TICKS_MID   = 600,
  parameter int TICKS_SHORT = 200,
  localparam int CNT_W      = $clog2(TICKS_LONG + 1)
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    start_i,
  input  logic    hold_i,
  input  period_e period_i,
  output logic    timeout_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             en;
  logic             armed;

  always_comb begin
    en = 1'b1;
    unique case (period_i)
      PER_LONG:  lim = CNT_W'(TICKS_LONG);
      PER_MID:   lim = CNT_W'(TICKS_MID);
      PER_SHORT: lim = CNT_W'(TICKS_SHORT);
      default: begin
        lim = '0;
        en  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt       <= '0;
      armed     <= 1'b1;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      if (hold_i) begin
        cnt   <= '0;
        armed <= 1'b1;
      end else if (start_i || !en) begin
        cnt <= '0;
      end else if (armed && tick_i) begin
        // >= so that a shorter period written mid-count still expires
        if (cnt >= lim - 1'b1) begin
          timeout_o <= 1'b1;
          cnt       <= '0;
          armed     <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bus_start_wdog.sv
module bus_start_wdog
  import bsw_pkg::*;
#(
  parameter int TICKS_LONG  = 1400,
  parameter int TICKS_MID   = 600,
  parameter int TICKS_SHORT = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_period_i,
  input  logic       cfg_wpen_i,
  input  logic       rst_hold_i,
  output logic [1:0] period_o,
  output logic       wpen_o,
  output logic       timeout_o
);
  logic [1:0] bus_s;
  logic       start;
  period_e    period;

  bsw_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       ({scl_i, sda_i}),
    .rst_val_i (2'b11),
    .q_o       (bus_s)
  );

  bsw_start_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (bus_s[1]),
    .sda_i   (bus_s[0]),
    .start_o (start)
  );

  bsw_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wp_i     (wp_i),
    .period_i (cfg_period_i),
    .wpen_i   (cfg_wpen_i),
    .period_o (period),
    .wpen_o   (wpen_o)
  );

  bsw_counter #(
    .TICKS_LONG  (TICKS_LONG),
    .TICKS_MID   (TICKS_MID),
    .TICKS_SHORT (TICKS_SHORT)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .start_i   (start),
    .hold_i    (rst_hold_i),
    .period_i  (period),
    .timeout_o (timeout_o)
  );

  assign period_o = period;
endmodule

// File: rtl/bus_start_wdog_chk.sv
module bus_start_wdog_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wp_i,
  input logic       cfg_we_i,
  input logic       rst_hold_i,
  input logic [1:0] period_o,
  input logic       wpen_o,
  input logic       timeout_o
);
  AST_TO_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R3

  AST_TO_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $past(tick_i)); // R3

  AST_TO_OFF_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(period_o) == 2'b11 |-> !timeout_o); // R4

  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && wp_i && wpen_o) |=> ($stable(period_o) && $stable(wpen_o))); // R5

  AST_NO_TO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_hold_i) |-> !timeout_o); // R6
endmodule

bind bus_start_wdog bus_start_wdog_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wp_i       (wp_i),
  .cfg_we_i   (cfg_we_i),
  .rst_hold_i (rst_hold_i),
  .period_o   (period_o),
  .wpen_o     (wpen_o),
  .timeout_o  (timeout_o)
);

// File: tb/sim_bus_start_wdog.sv
module sim_bus_start_wdog;
  localparam int TL = 24;
  localparam int TM = 16;
  localparam int TS = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, scl_i = 1'b1, sda_i = 1'b1, wp_i = 1'b0;
  logic cfg_we_i = 1'b0, cfg_wpen_i = 1'b0, rst_hold_i = 1'b0;
  logic [1:0] cfg_period_i = 2'b00;
  logic [1:0] period_o;
  logic wpen_o, timeout_o;

  int checks = 0, errors = 0, to_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_start_wdog #(.TICKS_LONG(TL), .TICKS_MID(TM), .TICKS_SHORT(TS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .scl_i(scl_i), .sda_i(sda_i),
    .wp_i(wp_i), .cfg_we_i(cfg_we_i), .cfg_period_i(cfg_period_i),
    .cfg_wpen_i(cfg_wpen_i), .rst_hold_i(rst_hold_i),
    .period_o(period_o), .wpen_o(wpen_o), .timeout_o(timeout_o)
  );

  always @(negedge clk) if (rst_ni && timeout_o) to_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm();
    @(negedge clk) rst_hold_i = 1'b1;
    wait_n(3);
    rst_hold_i = 1'b0;
    wait_n(2);
  endtask

  task automatic cfg_write(input logic [1:0] p, input logic en);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_period_i = p; cfg_wpen_i = en;
    @(negedge clk) cfg_we_i = 1'b0;
    wait_n(1);
  endtask

  task automatic t_reset();
    chk("R8 period", period_o, 0);
    chk("R8 wpen", wpen_o, 0);
    chk("R8 timeout", timeout_o, 0);
  endtask

  task automatic t_period(input logic [1:0] code, input int lim, input string tag);
    int base;
    cfg_write(code, 1'b0);
    chk({tag, " readback"}, period_o, code);
    rearm();
    base = to_cnt;
    ticks(lim - 1);
    chk({tag, " before limit"}, to_cnt - base, 0);
    ticks(1);
    chk({tag, " at limit"}, to_cnt - base, 1);
  endtask

  task automatic t_after_timeout();
    int base = to_cnt;
    ticks(20);
    chk("R7 idle after timeout", to_cnt - base, 0);
    @(negedge clk) rst_hold_i = 1'b1;
    ticks(12);
    chk("R6 no timeout in hold", to_cnt - base, 0);
    rst_hold_i = 1'b0;
    wait_n(2);
    ticks(TS - 1);
    chk("R6 fresh count after release", to_cnt - base, 0);
    ticks(1);
    chk("R6 expires after release", to_cnt - base, 1);
  endtask

  task automatic t_sda_low();
    int base;
    rearm();
    @(negedge clk) sda_i = 1'b0;
    wait_n(5);
    base = to_cnt;
    ticks(TS - 1);
    chk("R3 sda low before", to_cnt - base, 0);
    ticks(1);
    chk("R3 sda low expires", to_cnt - base, 1);
    @(negedge clk) scl_i = 1'b0;
    wait_n(1); sda_i = 1'b1;
    wait_n(1); scl_i = 1'b1;
    wait_n(5);
  endtask

  task automatic t_kick();
    int base;
    rearm();
    base = to_cnt;
    ticks(TS - 2);
    @(negedge clk) sda_i = 1'b0;
    wait_n(5);
    @(negedge clk) scl_i = 1'b0;
    wait_n(1); sda_i = 1'b1;
    wait_n(1); scl_i = 1'b1;
    wait_n(5);
    ticks(TS - 1);
    chk("R1 start restarts count", to_cnt - base, 0);
    ticks(1);
    chk("R1 expiry after start", to_cnt - base, 1);
  endtask

  task automatic t_non_start();
    int base;
    rearm();
    base = to_cnt;
    ticks(TS - 2);
    @(negedge clk) scl_i = 1'b0;
    wait_n(3); sda_i = 1'b0;
    wait_n(3); scl_i = 1'b1;
    wait_n(3); sda_i = 1'b1;
    wait_n(5);
    ticks(1);
    chk("R2 no restart yet", to_cnt - base, 0);
    ticks(1);
    chk("R2 count kept", to_cnt - base, 1);
  endtask

  task automatic t_off();
    int base;
    cfg_write(2'b11, 1'b0);
    rearm();
    base = to_cnt;
    ticks(100);
    chk("R4 code 11 disabled", to_cnt - base, 0);
  endtask

  task automatic t_lock();
    wp_i = 1'b0;
    cfg_write(2'b10, 1'b1);
    chk("R5 write unlocked period", period_o, 2);
    chk("R5 write unlocked wpen", wpen_o, 1);
    wp_i = 1'b1;
    cfg_write(2'b01, 1'b0);
    chk("R5 locked period kept", period_o, 2);
    chk("R5 locked wpen kept", wpen_o, 1);
    wp_i = 1'b0;
    cfg_write(2'b01, 1'b0);
    chk("R5 pin low period", period_o, 1);
    chk("R5 pin low wpen", wpen_o, 0);
    wp_i = 1'b1;
    cfg_write(2'b00, 1'b0);
    chk("R5 enable clear period", period_o, 0);
    wp_i = 1'b0;
  endtask

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(2);
    t_reset();
    t_period(2'b00, TL, "R4 long");
    t_period(2'b01, TM, "R4 mid");
    t_period(2'b10, TS, "R3 short");
    t_after_timeout();
    t_sda_low();
    t_kick();
    t_non_start();
    t_off();
    t_lock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual 0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule